// File: doc/BRIEF.md
# Configurable Aspect-Ratio Dual-Clock RAM

This block is a simple dual-port memory of 4,608 bits with one write port and one read port. Each port has its own clock, and the two clocks may be unrelated. Each port picks its own data width with a 3-bit shape code, so data written at one width can be read back at another. Supported widths are 1, 2, 4, 9, 18 and 36 bits. The 9/18/36 shapes use all 4,608 bits. The 1/2/4 shapes use 4,096 of them.

Storage is 128 rows of 36 bits. A narrow access selects a lane inside a wider word, with lane 0 in the least significant bits. Widths can be mixed freely inside the {9,18,36} family and inside the {1,2,4} family. Read data is registered in the read clock domain. When `rd_pipe` is high, a second register is placed after it and adds one cycle of latency. Results narrower than 36 bits come out in the low bits of `rd_data`.

Top module: `arp_ram`

## Requirements
- R1: Shape codes are 0=x1, 1=x2, 2=x4, 3=x9, 4=x18, 5=x36. A x36 access at address A uses row A[6:0]. A word written at x36 reads back unchanged at x36. Address bits above the shape's address width (12/11/10/9/8/7 bits for x1..x36) are ignored.
- R2: A x18 access at A uses the 18-bit lane A[0] of row A>>1. A x9 access at A uses the 9-bit lane A[1:0] of row A>>2. Lane 0 holds the least significant bits.
- R3: A x4 access at word W uses bits 4*(W mod 8) and up of row W>>3. A x2 access at A is lane A mod 2 of x4 word A>>1. A x1 access at A is lane A mod 4 of x4 word A>>2.
- R4: A write changes only the bits of its own lane. Shapes of 4 bits or narrower never change row bits 35:32.
- R5: With `rd_pipe` low, `rd_data` shows the word one `rd_clk` edge after the edge that samples `rd_en`. With `rd_pipe` high it shows it two edges after, because the pipeline register loads on every edge.
- R6: While `rd_en` is low, `rd_data` holds its value.
- R7: While `wr_en` is low, the memory is not changed.
- R8: Shape codes 6 and 7 are reserved. A write with them changes nothing, and a read with them leaves `rd_data` unchanged.
- R9: `rd_rst_n` low at an `rd_clk` edge clears both output registers to zero. Reset does not change the memory contents.
- R10: A read and a write to the same location on the same edge return the data held before the write.
- R11: Read results narrower than 36 bits are zero-extended in `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write port clock |
| wr_en | input | 1 | Write enable |
| wr_mode | input | 3 | Write shape code |
| wr_addr | input | 12 | Write address, low bits used per shape |
| wr_data | input | 36 | Write data, low bits used per shape |
| rd_clk | input | 1 | Read port clock |
| rd_rst_n | input | 1 | Synchronous active-low reset of the read registers |
| rd_en | input | 1 | Read enable |
| rd_mode | input | 3 | Read shape code |
| rd_addr | input | 12 | Read address, low bits used per shape |
| rd_pipe | input | 1 | Selects the extra output register |
| rd_data | output | 36 | Read data, zero-extended |

## Verification
The hardest case to reach is lane isolation in the narrow family. A 1-bit write must leave the other three bits of its nibble alone, the neighbouring nibbles alone, and the four spare bits at the top of the row alone. To show this, the stimulus first fills a row with a known x36 pattern that has the top nibble set. It then writes nibbles and single bits into that row and reads the whole row back at x36. A second hard case is the switch of `rd_pipe` while data is in flight. The bench waits one edge so that the pipeline register holds a known word, then counts edges to see the old word followed by the new one.

// File: rtl/arp_pkg.sv
// Package arp_pkg: shared constants and types of the aspect-ratio RAM.
// Assumes a fixed 128 x 36 storage array; all lane sizes derive from it.
package arp_pkg;
    localparam int ROW_W  = 36;
    localparam int ROWS   = 128;
    localparam int ROW_AW = $clog2(ROWS);
    localparam int ADDR_W = ROW_AW + 5;          // x1 address width
    localparam int OFF_W  = $clog2(ROW_W);
    localparam int WID_W  = $clog2(ROW_W) + 1;
    localparam int NIB_W  = 4;                    // widest narrow-family lane

    typedef enum logic [2:0] {
        SHP_X1  = 3'd0,
        SHP_X2  = 3'd1,
        SHP_X4  = 3'd2,
        SHP_X9  = 3'd3,
        SHP_X18 = 3'd4,
        SHP_X36 = 3'd5
    } shape_e;

    typedef struct packed {
        logic              ok;
        logic [ROW_AW-1:0] row;
        logic [OFF_W-1:0]  off;
        logic [WID_W-1:0]  wid;
    } lane_t;
endpackage

// File: rtl/arp_lane_map.sv
// Module arp_lane_map: turns a shape code and address into a row index,
// a bit offset inside the row and a lane width. Purely combinational.
// Assumes narrow shapes pack 4-bit words eight to a row (bits 31:0).
module arp_lane_map
    import arp_pkg::*;
(
    input  logic [2:0]        mode,
    input  logic [ADDR_W-1:0] addr,
    output lane_t             sel
);
    // Decode the shape into row, offset and width
    always_comb begin
        sel = '0;
        case (mode)
            SHP_X1: begin
                sel.ok  = 1'b1;
                sel.row = addr[ADDR_W-1:5];
                sel.off = OFF_W'(addr[4:0]);
                sel.wid = WID_W'(1);
            end
            SHP_X2: begin
                sel.ok  = 1'b1;
                sel.row = addr[ADDR_W-2:4];
                sel.off = OFF_W'({addr[3:0], 1'b0});
                sel.wid = WID_W'(2);
            end
            SHP_X4: begin
                sel.ok  = 1'b1;
                sel.row = addr[ADDR_W-3:3];
                sel.off = OFF_W'({addr[2:0], 2'b00});
                sel.wid = WID_W'(NIB_W);
            end
            SHP_X9: begin
                sel.ok  = 1'b1;
                sel.row = addr[ADDR_W-4:2];
                sel.off = OFF_W'(addr[1:0]) * OFF_W'(9);
                sel.wid = WID_W'(9);
            end
            SHP_X18: begin
                sel.ok  = 1'b1;
                sel.row = addr[ADDR_W-5:1];
                sel.off = addr[0] ? OFF_W'(18) : '0;
                sel.wid = WID_W'(18);
            end
            SHP_X36: begin
                sel.ok  = 1'b1;
                sel.row = addr[ROW_AW-1:0];
                sel.off = '0;
                sel.wid = WID_W'(ROW_W);
            end
            default: sel = '0;
        endcase
    end

    // R4
    lane_fits_chk: assert final (!sel.ok || (int'(sel.off) + int'(sel.wid) <= ROW_W));
endmodule

// File: rtl/arp_write_align.sv
// Module arp_write_align: builds the bit mask and the shifted data for
// a lane write. Combinational; assumes sel comes from arp_lane_map.
module arp_write_align
    import arp_pkg::*;
(
    input  logic             wr_en,
    input  lane_t            sel,
    input  logic [ROW_W-1:0] data_in,
    output logic [ROW_W-1:0] mask,
    output logic [ROW_W-1:0] data_sh
);
    logic [ROW_W-1:0] ones;

    // Form the lane mask and move the data into its lane
    always_comb begin
        ones    = {ROW_W{1'b1}} >> (ROW_W - int'(sel.wid));
        mask    = (wr_en && sel.ok) ? (ones << sel.off) : '0;
        data_sh = (data_in & ones) << sel.off;
    end

    // Check the mask against the decoded lane
    always_comb begin
        if (wr_en && !sel.ok) begin
            // R8
            reserved_write_chk: assert (mask == '0);
        end
        if (wr_en && sel.ok) begin
            // R4
            lane_mask_chk: assert ($countones(mask) == int'(sel.wid));
        end
        if (wr_en && sel.ok && sel.wid <= WID_W'(NIB_W)) begin
            // R4
            spare_bits_chk: assert (mask[ROW_W-1:32] == '0);
        end
    end
endmodule

// File: rtl/arp_read_path.sv
// Module arp_read_path: takes the lane out of a row word and registers it,
// with an optional second register. Synchronous active-low reset.
// Assumes word is the row addressed in the same cycle as en.
module arp_read_path
    import arp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ok,
    input  logic [OFF_W-1:0] off,
    input  logic [WID_W-1:0] wid,
    input  logic [ROW_W-1:0] word,
    input  logic             pipe,
    output logic [ROW_W-1:0] data_o
);
    logic             fire;
    logic [ROW_W-1:0] lane_val;
    logic [ROW_W-1:0] s1_q;
    logic [ROW_W-1:0] s2_q;

    // Take the addressed lane out of the row and zero-extend it
    always_comb begin
        fire     = en && ok;
        lane_val = (word >> off) & ({ROW_W{1'b1}} >> (ROW_W - int'(wid)));
    end

    // First output register, loads on an enabled read
    always_ff @(posedge clk) begin
        if (!rst_n)
            s1_q <= '0;
        else if (fire)
            s1_q <= lane_val;
    end

    // Pipeline register, follows the first register on every edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            s2_q <= '0;
        else
            s2_q <= s1_q;
    end

    // Choose the output stage
    always_comb data_o = pipe ? s2_q : s1_q;

    // R9
    rst_clears_chk: assert property (@(posedge clk) !rst_n |=> (data_o == '0));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && !$past(fire)) |=> (!$stable(pipe) || $stable(data_o)));

    // R8
    reserved_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !ok) |=> $stable(s1_q));

    // R11
    zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> ((s1_q >> $past(wid)) == '0));
endmodule

// File: rtl/arp_ram.sv
// Module arp_ram: 4,608-bit simple dual-port RAM. The two ports have
// independent clocks and independently chosen data widths. The write
// port has no reset; the read registers reset from rd_rst_n. Assumes
// widths are mixed only inside {1,2,4} or inside {9,18,36}.
module arp_ram
    import arp_pkg::*;
(
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [2:0]        wr_mode,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ROW_W-1:0]  wr_data,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    input  logic [2:0]        rd_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_pipe,
    output logic [ROW_W-1:0]  rd_data
);
    logic [ROW_W-1:0] mem [ROWS];
    lane_t            wr_sel;
    lane_t            rd_sel;
    logic [ROW_W-1:0] wr_mask;
    logic [ROW_W-1:0] wr_shift;
    logic [ROW_W-1:0] rd_word;

    arp_lane_map i_wr_map (
        .mode (wr_mode),
        .addr (wr_addr),
        .sel  (wr_sel)
    );

    arp_lane_map i_rd_map (
        .mode (rd_mode),
        .addr (rd_addr),
        .sel  (rd_sel)
    );

    arp_write_align i_align (
        .wr_en   (wr_en),
        .sel     (wr_sel),
        .data_in (wr_data),
        .mask    (wr_mask),
        .data_sh (wr_shift)
    );

    // Merge the written lane into its row on the write clock
    always_ff @(posedge wr_clk) begin
        if (wr_mask != '0)
            mem[wr_sel.row] <= (mem[wr_sel.row] & ~wr_mask) | (wr_shift & wr_mask);
    end

    // Fetch the addressed row for the read path
    always_comb rd_word = mem[rd_sel.row];

    arp_read_path i_rd (
        .clk    (rd_clk),
        .rst_n  (rd_rst_n),
        .en     (rd_en),
        .ok     (rd_sel.ok),
        .off    (rd_sel.off),
        .wid    (rd_sel.wid),
        .word   (rd_word),
        .pipe   (rd_pipe),
        .data_o (rd_data)
    );

    // R7
    no_write_chk: assert property (@(posedge wr_clk)
        (wr_en === 1'b0) |-> (wr_mask == '0));
endmodule

// File: tb/test_arp_ram.sv
// Bench for arp_ram: a vector table walked by one loop, then directed
// tests for reset, latency, hold and same-cycle collisions.
module test_arp_ram;
    localparam int N_VEC = 25;
    localparam int TMO   = 200000;

    logic        clk = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_mode = 3'd5;
    logic [11:0] wr_addr = '0;
    logic [35:0] wr_data = '0;
    logic        rd_rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_mode = 3'd5;
    logic [11:0] rd_addr = '0;
    logic        rd_pipe = 1'b0;
    logic [35:0] rd_data;
    int          n_chk = 0;
    int          n_err = 0;

    always #10 clk = ~clk;

    arp_ram i_arp_ram (
        .wr_clk (clk), .wr_en (wr_en), .wr_mode (wr_mode), .wr_addr (wr_addr),
        .wr_data (wr_data), .rd_clk (clk), .rd_rst_n (rd_rst_n), .rd_en (rd_en),
        .rd_mode (rd_mode), .rd_addr (rd_addr), .rd_pipe (rd_pipe), .rd_data (rd_data)
    );

    // Vector: {read(1), req(4), mode(3), addr(12), data or expected(36)}
    localparam logic [35:0] C5 = {9'h0AA, 9'h155, 9'h0F3, 9'h1A5};
    localparam logic [35:0] V7 = {18'h3FFFF, 18'h1EF01};
    localparam logic [35:0] N7 = 36'h123456789;
    localparam logic [55:0] VEC [N_VEC] = '{
        {1'b0, 4'd4,  3'd5, 12'd2,    36'hF00000000},        // R4 preset row 2
        {1'b0, 4'd2,  3'd3, 12'd20,   36'h1A5},              // R2
        {1'b0, 4'd2,  3'd3, 12'd21,   36'h0F3},
        {1'b0, 4'd2,  3'd3, 12'd22,   36'h155},
        {1'b0, 4'd2,  3'd3, 12'd23,   36'h0AA},
        {1'b1, 4'd2,  3'd5, 12'd5,    C5},                   // R2
        {1'b1, 4'd2,  3'd4, 12'd10,   {18'h0, 9'h0F3, 9'h1A5}},
        {1'b1, 4'd2,  3'd4, 12'd11,   {18'h0, 9'h0AA, 9'h155}},
        {1'b1, 4'd11, 3'd3, 12'd22,   36'h155},              // R11
        {1'b1, 4'd1,  3'd5, 12'h085,  C5},                   // R1 upper bits ignored
        {1'b0, 4'd1,  3'd5, 12'd7,    36'h9ABCDEF01},        // R1
        {1'b1, 4'd1,  3'd5, 12'd7,    36'h9ABCDEF01},
        {1'b0, 4'd4,  3'd4, 12'd15,   36'h3FFFF},            // R4
        {1'b1, 4'd4,  3'd5, 12'd7,    V7},
        {1'b0, 4'd3,  3'd2, 12'd16,   36'hA},                // R3
        {1'b0, 4'd3,  3'd2, 12'd17,   36'h5},
        {1'b1, 4'd3,  3'd0, 12'd64,   36'h0},
        {1'b1, 4'd3,  3'd0, 12'd65,   36'h1},
        {1'b1, 4'd3,  3'd1, 12'd33,   36'h2},
        {1'b1, 4'd3,  3'd1, 12'd34,   36'h1},
        {1'b0, 4'd4,  3'd0, 12'd66,   36'h1},                // R4
        {1'b1, 4'd4,  3'd2, 12'd16,   36'hE},
        {1'b1, 4'd4,  3'd5, 12'd2,    36'hF0000005E},
        {1'b0, 4'd8,  3'd6, 12'd5,    36'hFFFFFFFFF},        // R8
        {1'b1, 4'd8,  3'd5, 12'd5,    C5}
    };

    // Compare one value and report a mismatch
    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One write cycle
    task automatic do_write(input logic [2:0] m, input logic [11:0] a, input logic [35:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_mode = m; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One read cycle; result valid at the following negedge when rd_pipe is low
    task automatic do_read(input logic [2:0] m, input logic [11:0] a, output logic [35:0] q);
        @(negedge clk);
        rd_en = 1'b1; rd_mode = m; rd_addr = a;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        q = rd_data;
    endtask

    // Watchdog
    initial begin
        repeat (TMO) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [35:0] q;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset value", rd_data, 36'h0);
        rd_rst_n = 1'b1;

        for (int i = 0; i < N_VEC; i++) begin
            if (VEC[i][55]) begin
                do_read(VEC[i][50:48], VEC[i][47:36], q);
                check($sformatf("R%0d vector %0d", VEC[i][54:51], i), q, VEC[i][35:0]);
            end else begin
                do_write(VEC[i][50:48], VEC[i][47:36], VEC[i][35:0]);
            end
        end

        // R6: address changes with rd_en low
        @(negedge clk);
        rd_addr = 12'd7;
        repeat (3) @(negedge clk);
        check("R6 hold while idle", rd_data, C5);

        // R8: reserved read code leaves output
        do_read(3'd7, 12'd7, q);
        check("R8 reserved read", q, C5);

        // R7: data on the bus without wr_en
        @(negedge clk);
        wr_mode = 3'd5; wr_addr = 12'd7; wr_data = 36'h0;
        repeat (2) @(negedge clk);
        do_read(3'd5, 12'd7, q);
        check("R7 no write when disabled", q, V7);

        // R10: same-edge read and write
        @(negedge clk);
        wr_en = 1'b1; wr_mode = 3'd5; wr_addr = 12'd7; wr_data = N7;
        rd_en = 1'b1; rd_mode = 3'd5; rd_addr = 12'd7;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R10 old data on collision", rd_data, V7);
        do_read(3'd5, 12'd7, q);
        check("R10 new data after", q, N7);

        // R5: pipeline latency
        @(negedge clk);
        rd_pipe = 1'b1;
        @(negedge clk);
        rd_en = 1'b1; rd_mode = 3'd5; rd_addr = 12'd5;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        check("R5 pipe first edge", rd_data, N7);
        @(negedge clk);
        check("R5 pipe second edge", rd_data, C5);
        rd_pipe = 1'b0;

        // R9: reset clears output, keeps memory
        @(negedge clk);
        rd_rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset clears output", rd_data, 36'h0);
        rd_rst_n = 1'b1;
        do_read(3'd5, 12'd7, q);
        check("R9 memory kept", q, N7);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule